// File: doc/BRIEF.md
# Upset-Imitating Protected Register

The block holds one protected storage word of thirteen bits: eight information bits and five check bits. Its purpose is early reliability estimation, which works by flipping chosen bits of that word on command, the way a particle strike would. The code that produces and checks the check bits lives outside the block, so the check bits arrive already computed together with the data. Downstream detection and correction logic then reads the possibly corrupted word from the output.

Fault masks come from a four-bit maximal-length LFSR. In precise mode every injection strobe reloads the LFSR from the user seed and advances it once, so the same seed always gives the same mask. In random mode the LFSR is seeded only at reset, and each strobe advances the sequence further. One four-bit window of the word receives the mask as an XOR, and the target select picks that window. The strobe is a single-cycle pulse in the main clock domain and marks the exact cycle at which the fault lands. Normal operation, with no injection, is the default mode.

Top module: `seu_injector`

## Requirements
- R1: While rst_n is low the stored word reads all zeros. On the first cycle after reset it still reads zero.
- R2: A write (wr_en high) stores wr_info in bits 12..5 and wr_chk in bits 4..0. The new word appears at the output after the next rising edge, in every mode.
- R3: In normal mode (mode = 0) and in the spare code (mode = 3), an injection strobe changes neither the word nor the LFSR state.
- R4: In precise mode (mode = 1), a strobe without a write XORs the target window with step(S). S is the corrected seed and step(x) = {x[2:0], x[3]^x[2]}, which is the x^4+x^3+1 feedback. Repeating the same seed gives the same mask every time.
- R5: In random mode (mode = 2), reset loads the LFSR with the corrected seed. Each strobe without a write sets the LFSR to step(state) and XORs the target window with that new state.
- R6: tgt_sel selects the window: 0 = bits 12..9 (upper information nibble), 1 = bits 8..5 (lower information nibble), 2 = bits 3..0, 3 = bits 4..1. Bits outside the window keep their value.
- R7: A seed of 0000 is treated as 0001, so the LFSR state is never zero.
- R8: When a write and a strobe fall in the same cycle, only the write takes effect. The LFSR does not advance.
- R9: With neither a write nor a strobe, the word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; also loads the LFSR seed |
| mode | input | 2 | 0 normal, 1 precise, 2 random, 3 treated as normal |
| seed | input | 4 | LFSR seed |
| inj_stb | input | 1 | Single-cycle injection strobe |
| tgt_sel | input | 2 | Target window select |
| wr_en | input | 1 | Normal write enable |
| wr_info | input | 8 | Information bits to store |
| wr_chk | input | 5 | Precomputed check bits to store |
| word_q | output | 13 | Stored, possibly corrupted word |

## Verification
The assertions check four things on every cycle: the word holds when idle, a write lands with the correct field layout, bits outside the selected window stay untouched during an injection, and the LFSR state never becomes zero. The exact mask values, and how they differ between the reloaded precise seed and the advancing random sequence, only the bench scenarios can show. The same applies to the zero-seed substitution and to the proof that an ignored strobe or a losing strobe left the sequence where it was. Those scenarios compare the output against a model of the feedback polynomial.

// File: rtl/seu_injector.sv
module seu_injector #(
  parameter int INFO_W = 8,
  parameter int CHK_W  = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                mode,
  input  logic [3:0]                seed,
  input  logic                      inj_stb,
  input  logic [1:0]                tgt_sel,
  input  logic                      wr_en,
  input  logic [INFO_W-1:0]         wr_info,
  input  logic [CHK_W-1:0]          wr_chk,
  output logic [INFO_W+CHK_W-1:0]   word_q
);
  localparam int WORD_W = INFO_W + CHK_W;
  localparam int NIB    = 4;
  localparam int OFF_HI = WORD_W - NIB;
  localparam int OFF_LO = CHK_W;
  localparam int OFF_C0 = 0;
  localparam int OFF_C1 = CHK_W - NIB;

  logic [NIB-1:0]    lfsr_q;
  logic [NIB-1:0]    seed_fix;
  logic [NIB-1:0]    base;
  logic [NIB-1:0]    mask;
  logic [WORD_W-1:0] mask_w;
  logic              inj_ok;

  function automatic logic [NIB-1:0] step(input logic [NIB-1:0] s);
    return {s[NIB-2:0], s[NIB-1] ^ s[NIB-2]};
  endfunction

  assign seed_fix = (seed == '0) ? NIB'(1) : seed;
  assign base     = (mode == 2'd1) ? seed_fix : lfsr_q;
  assign mask     = step(base);
  assign inj_ok   = inj_stb && !wr_en && (mode == 2'd1 || mode == 2'd2);

  always_comb begin
    mask_w = '0;
    case (tgt_sel)
      2'd0:    mask_w[OFF_HI +: NIB] = mask;
      2'd1:    mask_w[OFF_LO +: NIB] = mask;
      2'd2:    mask_w[OFF_C0 +: NIB] = mask;
      default: mask_w[OFF_C1 +: NIB] = mask;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      lfsr_q <= seed_fix;
    end else if (wr_en) begin
      word_q <= {wr_info, wr_chk};
    end else if (inj_ok) begin
      word_q <= word_q ^ mask_w;
      if (mode == 2'd2) lfsr_q <= mask;
    end
  end
endmodule

// File: rtl/seu_injector_chk.sv
module seu_injector_chk #(
  parameter int INFO_W = 8,
  parameter int CHK_W  = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    inj_stb,
  input logic [1:0]              tgt_sel,
  input logic                    wr_en,
  input logic [INFO_W-1:0]       wr_info,
  input logic [CHK_W-1:0]        wr_chk,
  input logic [INFO_W+CHK_W-1:0] word_q,
  input logic [3:0]              lfsr_q
);
  localparam int WORD_W = INFO_W + CHK_W;

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !inj_stb) |=> $stable(word_q));

  // R2
  write_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> word_q == {$past(wr_info), $past(wr_chk)});

  // R6
  window_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_stb && !wr_en && tgt_sel == 2'd0) |=>
      word_q[WORD_W-5:0] == $past(word_q[WORD_W-5:0]));

  // R6
  window_c0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_stb && !wr_en && tgt_sel == 2'd2) |=>
      word_q[WORD_W-1:4] == $past(word_q[WORD_W-1:4]));

  // R7
  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> lfsr_q != 4'd0);
endmodule

bind seu_injector seu_injector_chk #(.INFO_W(INFO_W), .CHK_W(CHK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .inj_stb(inj_stb), .tgt_sel(tgt_sel),
  .wr_en(wr_en), .wr_info(wr_info), .wr_chk(wr_chk),
  .word_q(word_q), .lfsr_q(lfsr_q)
);

// File: tb/sim_seu_injector.sv
`timescale 1ns/1ps
module sim_seu_injector;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic [3:0]  seed;
  logic        inj_stb;
  logic [1:0]  tgt_sel;
  logic        wr_en;
  logic [7:0]  wr_info;
  logic [4:0]  wr_chk;
  logic [12:0] word_q;

  int nvec = 0;
  int nerr = 0;
  logic [12:0] exp_w;
  logic [3:0]  exp_l;

  always #2.5 clk = ~clk;

  seu_injector u0 (.clk(clk), .rst_n(rst_n), .mode(mode), .seed(seed),
    .inj_stb(inj_stb), .tgt_sel(tgt_sel), .wr_en(wr_en), .wr_info(wr_info),
    .wr_chk(wr_chk), .word_q(word_q));

  function automatic logic [3:0] nxt(input logic [3:0] s);
    return {s[2:0], s[3] ^ s[2]};
  endfunction

  function automatic logic [12:0] place(input logic [1:0] sel, input logic [3:0] m);
    case (sel)
      2'd0:    return {m, 9'd0};
      2'd1:    return {4'd0, m, 5'd0};
      2'd2:    return {9'd0, m};
      default: return {8'd0, m, 1'b0};
    endcase
  endfunction

  task automatic check(input string req, input logic [12:0] exp);
    nvec++;
    if (word_q !== exp) begin
      nerr++;
      $display("FAIL %s: word=%h expected=%h", req, word_q, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    inj_stb = 1'b0; wr_en = 1'b0;
  endtask

  task automatic do_reset(input logic [3:0] s);
    rst_n = 1'b0; seed = s; mode = 2'd2;
    tick(); tick();
    check("R1", 13'd0);
    rst_n = 1'b1;
    tick();
    check("R1", 13'd0);
    exp_w = '0;
    exp_l = (s == 4'd0) ? 4'd1 : s;
  endtask

  task automatic do_write(input logic [7:0] i, input logic [4:0] c);
    wr_en = 1'b1; wr_info = i; wr_chk = c;
    tick();
    exp_w = {i, c};
    check("R2", exp_w);
  endtask

  task automatic rand_inj(input logic [1:0] sel);
    mode = 2'd2; tgt_sel = sel; inj_stb = 1'b1;
    tick();
    exp_l = nxt(exp_l);
    exp_w = exp_w ^ place(sel, exp_l);
    check("R5", exp_w);
  endtask

  task automatic prec_inj(input logic [3:0] s, input logic [1:0] sel, input string req);
    logic [3:0] sf;
    mode = 2'd1; seed = s; tgt_sel = sel; inj_stb = 1'b1;
    tick();
    sf = (s == 4'd0) ? 4'd1 : s;
    exp_w = exp_w ^ place(sel, nxt(sf));
    check(req, exp_w);
  endtask

  task automatic ignored_inj(input logic [1:0] m);
    mode = m; tgt_sel = 2'd0; inj_stb = 1'b1;
    tick();
    check("R3", exp_w);
  endtask

  task automatic collide();
    mode = 2'd2; tgt_sel = 2'd1; inj_stb = 1'b1;
    wr_en = 1'b1; wr_info = 8'h3C; wr_chk = 5'h0A;
    tick();
    exp_w = {8'h3C, 5'h0A};
    check("R8", exp_w);
  endtask

  task automatic idle();
    tick(); tick();
    check("R9", exp_w);
  endtask

  initial begin
    #(200000 * 5);
    nerr++;
    $display("FAIL watchdog: word=%h expected=%h", word_q, exp_w);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 2'd0; seed = 4'd0; inj_stb = 1'b0; tgt_sel = 2'd0;
    wr_en = 1'b0; wr_info = '0; wr_chk = '0;
    @(negedge clk);
    do_reset(4'b0110);
    do_write(8'hA5, 5'h1B);
    rand_inj(2'd0);
    rand_inj(2'd0);
    ignored_inj(2'd0);
    ignored_inj(2'd3);
    rand_inj(2'd1);   // R3: sequence resumes where it stopped
    collide();
    rand_inj(2'd2);   // R8: LFSR did not advance on the collision
    prec_inj(4'b1001, 2'd1, "R4");
    prec_inj(4'b1001, 2'd1, "R4");
    prec_inj(4'b0101, 2'd2, "R6");
    prec_inj(4'b1110, 2'd3, "R6");
    prec_inj(4'b1011, 2'd0, "R6");
    prec_inj(4'b0000, 2'd1, "R7");
    rand_inj(2'd3);   // R5: precise mode left the sequence alone
    idle();
    do_reset(4'b0000);
    do_write(8'hFF, 5'h1F);
    rand_inj(2'd0);   // R7: zero seed in random mode
    rand_inj(2'd1);
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule